// File: doc/BRIEF.md
# Address-Masked GPIO Port with Per-Pin Interrupts

This block is an eight-line general-purpose I/O port that sits on a simple peripheral register bus. Each line can be set as an input or an output. An output latch drives the lines that are outputs. The data register is reached through a window of addresses. The word-address bits act as a per-bit mask, so software can set or read any subset of pins in a single access, without a read-modify-write sequence.

Every pin has its own interrupt detector. The detector can be level-sensitive or edge-sensitive, active high/rising or active low/falling, or, for edge mode, triggered by any transition. Software reads the raw status and the enabled (masked) status, and acknowledges edge events by writing ones to a clear register. All enabled events are combined into one interrupt line.

The bus is a two-phase select/enable protocol with no wait states. A write takes effect on the clock edge of its enable phase, and read data is valid during the enable phase. The block applies no back-pressure: every access finishes in its enable cycle, so the bus has no ready signal.

Top module: `mgpio_top`

## Requirements
- R1: After reset, every line is an input (`gpio_oe` = 0), the output latch is 0, the interrupt enables are 0 and `irq` is low.
- R2: A write to byte offset 0x000–0x3FC changes only the output-latch bits whose mask bit `paddr[9:2]` is 1; offset `1 << (n+2)` updates pin n alone.
- R3: A read in the data window returns the pin values in the bits whose mask bit `paddr[9:2]` is 1, and 0 in all other bits. An output pin reads its latch value. An input pin reads its input after two synchronizer flops.
- R4: Direction register (offset 0x400): bit value 1 makes the pin an output (`gpio_oe` high, `gpio_out` driven from the latch); bit value 0 makes it an input.
- R5: When sense bit (0x404) is 1 the pin is level-sensitive. Its raw status is 1 while the synchronized input equals the event bit (0x40C), and it is not latched.
- R6: When sense bit is 0 the pin is edge-sensitive. Event bit 1 latches raw status on a rising edge; event bit 0 latches it on a falling edge.
- R7: Both-edges bit (0x408) value 1 makes an edge-sensitive pin latch on any transition, whatever the event bit is.
- R8: Masked status (0x418) equals raw status (0x414) AND enable (0x410). Writes to both status registers are ignored.
- R9: Writing 1 to a bit of the clear register (0x41C) clears the latched edge status of that pin. Writing 0 leaves it unchanged. The clear register reads as 0.
- R10: `irq` is the OR of all masked status bits.
- R11: When an edge is detected in the same cycle as a clear for that pin, the pin's status stays set.
- R12: Reads of unmapped offsets (0x420 and above) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Enable (second) phase of an access |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid in the enable phase |
| gpio_in | input | 8 | Asynchronous pin inputs |
| gpio_out | output | 8 | Output latch values |
| gpio_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
Masked data accesses are tested with random address masks over random directions and random latch contents. This shows whether unselected bits stay untouched on writes and read as zero, and whether output pins return the latch while input pins return the pad. Interrupt detection is tested with random sense, polarity, both-edges and enable settings against random old/new pin levels. This separates level from edge behaviour, rising from falling, and both-edges from single-edge. A random partial clear is then applied to check write-one-to-clear. Directed cases cover reset values, read-only status, unmapped reads, single-pin addressing and an edge that arrives in the same cycle as its clear.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  // configuration register slots, word index paddr[4:2] above the data window
  typedef enum logic [2:0] {
    SLOT_DIR    = 3'd0,
    SLOT_SENSE  = 3'd1,
    SLOT_BOTH   = 3'd2,
    SLOT_EVENT  = 3'd3,
    SLOT_ENABLE = 3'd4,
    SLOT_RAW    = 3'd5,
    SLOT_MASKED = 3'd6,
    SLOT_CLEAR  = 3'd7
  } cfg_slot_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mgpio_irq.sv
module mgpio_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] event_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[p] & ~prev_q[p];
    assign fall = ~lvl_i[p] & prev_q[p];
    always_comb begin
      if (sense_i[p])     hit[p] = 1'b0;
      else if (both_i[p]) hit[p] = rise | fall;
      else if (event_i[p]) hit[p] = rise;
      else                hit[p] = fall;
    end
    // level pins follow the line, edge pins show the latch
    assign raw_o[p] = sense_i[p] ? ~(lvl_i[p] ^ event_i[p]) : lat_q[p];
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~clr_i) | hit;
  end

  AST_CLEAR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lat_q) & ~$past(clr_i) & ~lat_q) == '0)); // R9
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~lat_q) == '0)); // R11
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = W + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  output logic [W-1:0]  prdata,
  input  logic [W-1:0]  pin_view_i,
  input  logic [W-1:0]  raw_i,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  latch_o,
  output logic [W-1:0]  sense_o,
  output logic [W-1:0]  both_o,
  output logic [W-1:0]  event_o,
  output logic [W-1:0]  enable_o,
  output logic [W-1:0]  clr_o
);
  localparam int unsigned TOP_W = AW - (W + 2);

  logic            wr_en, rd_en;
  logic            in_win, in_cfg;
  logic [W-1:0]    win_mask;
  cfg_slot_e       slot;
  logic [TOP_W-1:0] region;

  assign region   = paddr[AW-1:W+2];
  assign win_mask = paddr[W+1:2];
  assign slot     = cfg_slot_e'(paddr[4:2]);
  assign in_win   = (region == '0);
  assign in_cfg   = (region == TOP_W'(1)) && (paddr[W+1:5] == '0);
  assign wr_en    = psel & penable & pwrite;
  assign rd_en    = psel & ~pwrite;

  logic wr_win, wr_cfg;
  assign wr_win = wr_en & in_win;
  assign wr_cfg = wr_en & in_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_o  <= '0;
      dir_o    <= '0;
      sense_o  <= '0;
      both_o   <= '0;
      event_o  <= '0;
      enable_o <= '0;
    end else begin
      if (wr_win) latch_o <= (latch_o & ~win_mask) | (pwdata & win_mask);
      if (wr_cfg) begin
        case (slot)
          SLOT_DIR:    dir_o    <= pwdata;
          SLOT_SENSE:  sense_o  <= pwdata;
          SLOT_BOTH:   both_o   <= pwdata;
          SLOT_EVENT:  event_o  <= pwdata;
          SLOT_ENABLE: enable_o <= pwdata;
          default:     ;
        endcase
      end
    end
  end

  assign clr_o = (wr_cfg && slot == SLOT_CLEAR) ? pwdata : '0;

  always_comb begin
    prdata = '0;
    if (rd_en && in_win) begin
      prdata = pin_view_i & win_mask;
    end else if (rd_en && in_cfg) begin
      case (slot)
        SLOT_DIR:    prdata = dir_o;
        SLOT_SENSE:  prdata = sense_o;
        SLOT_BOTH:   prdata = both_o;
        SLOT_EVENT:  prdata = event_o;
        SLOT_ENABLE: prdata = enable_o;
        SLOT_RAW:    prdata = raw_i;
        SLOT_MASKED: prdata = raw_i & enable_o;
        default:     prdata = '0;
      endcase
    end
  end

  AST_MASKED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_win |=> (((latch_o ^ $past(latch_o)) & ~$past(win_mask)) == '0)); // R2
  AST_UNSELECTED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_win) |-> ((prdata & ~win_mask) == '0)); // R3
  AST_STATUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && (slot == SLOT_RAW || slot == SLOT_MASKED)) |=> $stable(enable_o)); // R8
endmodule

// File: rtl/mgpio_top.sv
module mgpio_top
  import mgpio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [7:0]  pwdata,
  output logic [7:0]  prdata,
  input  logic [7:0]  gpio_in,
  output logic [7:0]  gpio_out,
  output logic [7:0]  gpio_oe,
  output logic        irq
);
  localparam int unsigned NPINS = 8;
  localparam int unsigned AW    = NPINS + 4;

  logic [NPINS-1:0] pin_sync, pin_view, raw, dir, latch;
  logic [NPINS-1:0] sense, both, evt, enable, clr;

  mgpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(gpio_in), .sync_o(pin_sync)
  );

  assign pin_view = (dir & latch) | (~dir & pin_sync);

  mgpio_regs #(.W(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_view_i(pin_view), .raw_i(raw),
    .dir_o(dir), .latch_o(latch), .sense_o(sense), .both_o(both),
    .event_o(evt), .enable_o(enable), .clr_o(clr)
  );

  mgpio_irq #(.W(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_sync), .sense_i(sense),
    .both_i(both), .event_i(evt), .clr_i(clr), .raw_o(raw)
  );

  assign gpio_out = latch;
  assign gpio_oe  = dir;
  assign irq      = |(raw & enable);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enable != '0)); // R10
  AST_OE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_oe) |-> $past(psel & penable & pwrite)); // R4
endmodule

// File: tb/mgpio_top_bench.sv
module mgpio_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata;
  logic [7:0]  gpio_in = '0;
  logic [7:0]  gpio_out, gpio_oe;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_EVT = 12'h40C, A_EN = 12'h410, A_RAW = 12'h414,
                          A_MSK = 12'h418, A_CLR = 12'h41C;

  always #10 clk = ~clk;

  mgpio_top u_mgpio_top (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #2 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_raw(input logic [7:0] sen, input logic [7:0] bth,
      input logic [7:0] ev, input logic [7:0] oldv, input logic [7:0] newv);
    logic [7:0] ch, edg;
    ch  = oldv ^ newv;
    edg = ch & (bth | (ev & newv) | (~ev & ~newv));
    return (sen & ~(newv ^ ev)) | (~sen & edg);
  endfunction

  initial begin
    logic [7:0] rd, m_dir, m_lat, msk, d, oldv, newv, sen, bth, ev, en, er, c;
    void'($urandom(32'h1d0c5eed));
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    check("R1 oe", gpio_oe, 8'h00);
    check("R1 out", gpio_out, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    bus_rd(A_EN, rd);  check("R1 enable", rd, 8'h00);
    bus_rd(A_DIR, rd); check("R4 dir reset", rd, 8'h00);

    // R2 single pin addressing
    m_lat = 8'h00;
    for (int n = 0; n < 8; n += 2) begin
      bus_wr(12'(1 << (n + 2)), 8'hFF);
      m_lat[n] = 1'b1;
      check("R2 single pin", gpio_out, m_lat);
    end
    // R4 direction
    m_dir = 8'h0F;
    bus_wr(A_DIR, m_dir);
    check("R4 oe", gpio_oe, m_dir);

    // R2/R3 random masked accesses
    for (int i = 0; i < 40; i++) begin
      msk = 8'($urandom); d = 8'($urandom);
      if (i % 8 == 0) begin m_dir = 8'($urandom); bus_wr(A_DIR, m_dir); end
      gpio_in = 8'($urandom);
      bus_wr({2'b00, msk, 2'b00}, d);
      m_lat = (m_lat & ~msk) | (d & msk);
      check("R2 masked write", gpio_out, m_lat);
      msk = 8'($urandom);
      bus_rd({2'b00, msk, 2'b00}, rd);
      check("R3 masked read", rd, ((m_dir & m_lat) | (~m_dir & gpio_in)) & msk);
    end
    bus_wr(A_DIR, 8'h00);

    // R12 / R8 read-only and unmapped
    bus_wr(A_EN, 8'h3C);
    bus_wr(A_RAW, 8'hFF);
    bus_wr(A_MSK, 8'hFF);
    bus_rd(A_EN, rd);  check("R8 status writes ignored", rd, 8'h3C);
    bus_rd(A_CLR, rd); check("R9 clear reads zero", rd, 8'h00);
    bus_rd(12'h420, rd); check("R12 unmapped", rd, 8'h00);
    bus_rd(12'h7E0, rd); check("R12 unmapped high", rd, 8'h00);

    // R5-R10 random interrupt configurations
    for (int i = 0; i < 40; i++) begin
      oldv = 8'($urandom);
      gpio_in = oldv; idle(4);
      sen = 8'($urandom); bth = 8'($urandom); ev = 8'($urandom); en = 8'($urandom);
      if (i < 4) begin sen = (i < 2) ? 8'hFF : 8'h00; bth = 8'h00; ev = (i % 2) ? 8'hFF : 8'h00; end
      bus_wr(A_SENSE, sen); bus_wr(A_BOTH, bth); bus_wr(A_EVT, ev); bus_wr(A_EN, en);
      bus_wr(A_CLR, 8'hFF);
      newv = 8'($urandom);
      gpio_in = newv; idle(5);
      er = exp_raw(sen, bth, ev, oldv, newv);
      bus_rd(A_RAW, rd); check("R5 R6 R7 raw", rd, er);
      bus_rd(A_MSK, rd); check("R8 masked", rd, er & en);
      check("R10 irq", {7'b0, irq}, {7'b0, |(er & en)});
      c = 8'($urandom);
      bus_wr(A_CLR, c);
      er = (sen & er) | (~sen & er & ~c);
      bus_rd(A_RAW, rd); check("R9 partial clear", rd, er);
    end

    // R5 level not latched
    bus_wr(A_SENSE, 8'h01); bus_wr(A_EVT, 8'h01); bus_wr(A_EN, 8'h01);
    gpio_in = 8'h01; idle(4);
    check("R5 level high irq", {7'b0, irq}, 8'h01);
    gpio_in = 8'h00; idle(4);
    check("R5 level released", {7'b0, irq}, 8'h00);

    // R11 edge and clear in the same cycle
    bus_wr(A_SENSE, 8'h00); bus_wr(A_BOTH, 8'h00); bus_wr(A_EVT, 8'h01);
    bus_wr(A_CLR, 8'hFF);
    @(negedge clk); gpio_in = 8'h01;
    bus_wr(A_CLR, 8'h01);
    bus_rd(A_RAW, rd); check("R11 edge wins", rd, 8'h01);
    bus_wr(A_CLR, 8'h01);
    bus_rd(A_RAW, rd); check("R9 later clear", rd, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        miscompares++; vectors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule